// File: doc/BRIEF.md
# Addressed Serial Link Slave

This block is the device end of a two-wire synchronous link: a bus clock that only the controller drives, and one shared data line. Every transfer is a 12-bit frame. A high start bit opens the frame, the second bit tells control frames (low) from data frames (high), a turnaround bit follows, then eight data bits least significant first, and a closing turnaround bit ends it. The slave holds a fixed, nonzero 6-bit address. It decodes control bytes that reset, select or deselect it. Once selected, it takes commands that set the transfer direction and whether one byte or a stream of bytes follows.

The bus clock and the data line are sampled with the local system clock. Bus-clock rising edges latch incoming bits. Falling edges are when the slave changes its own output. Received data bytes and the four free command bits go to local logic, each with a one-cycle strobe. When the slave must send, it pulses a request and takes the transmit byte in that cycle. A one-cycle local reset pulse reports a reset addressed to this slave.

Top module: `link_slave`

## Requirements
- R1: After reset the data-line enable, all strobes, the request and the local reset output are low.
- R2: A frame starts only on a sampled high start bit and lasts 12 bus-clock rising edges. An all-zero null frame produces no strobe, no request and no drive.
- R3: A control byte with bit 7 = 0 and bit 6 = 0 whose low six bits are zero or equal the slave address gives a one-cycle local reset pulse and leaves the slave deselected in control-only mode. Any other address leaves the state unchanged.
- R4: A control byte with bit 7 = 0 and bit 6 = 1 and the slave's own address selects the slave. The next data input frame is answered with the nonzero information byte parameter.
- R5: The same select byte carrying address zero or another slave's address deselects the slave without a local reset pulse.
- R6: While selected, a control byte with bit 7 = 1 and bit 5 = 0 pulses the command strobe with bits 3:0 on the command nibble. Bit 6 = 1 means read and 0 means write, and bit 4 = 1 means multi-transfer. While deselected, such bytes are ignored.
- R7: In write mode each data output frame delivers its eight data bits (first received = bit 0) on the data byte output with a one-cycle strobe.
- R8: In read mode each data input frame raises the transmit request once, and the byte presented in that cycle goes out least significant bit first.
- R9: In single mode one data frame completes the transfer and later data frames are ignored. In multi mode transfers go on until the next control frame.
- R10: A control frame is decoded in every mode and replaces the current mode.
- R11: In a frame the slave answers, the line is driven exactly during frame cycles 4 to 11. It is released from the falling edge that opens cycle 12.
- R12: A deselected slave ignores data frames and never drives the data line.
- R13: A slave-control byte with bit 5 = 1 (byte-pair size) gives no command strobe and leaves the slave in control-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Link clock from the controller |
| bus_dat_i | input | 1 | Sampled level of the shared data line |
| bus_dat_o | output | 1 | Value the slave puts on the data line |
| bus_dat_oe | output | 1 | Enable for bus_dat_o |
| dat_vld | output | 1 | One-cycle strobe for a received data byte |
| dat_byte | output | 8 | Received data byte |
| cmd_vld | output | 1 | One-cycle strobe for an accepted command |
| cmd_nib | output | 4 | Free command bits of that command |
| tx_req | output | 1 | Transmit byte is taken in this cycle |
| tx_byte | input | 8 | Byte to send in read mode |
| loc_rst | output | 1 | One-cycle local reset pulse |

## Verification
The bench builds the slave with address 37 and information byte 0xC3, and paces the link at six system clocks per bus-clock phase. With a 6-bit address, all 64 codes can be swept through both select and reset bytes, so every hit, miss and the address-zero cases are covered. With an 8-bit data path, every one of the 256 byte values goes through a single multi-write stream, with null frames mixed in. A 64-step read stream and the mode-change, single-transfer, byte-pair and deselected cases complete the run.

// File: rtl/lsl_pkg.sv
// Shared constants and types for the addressed serial link slave.
// Assumes 12-bit frames carrying one data byte each.
package lsl_pkg;
    localparam int FRAME_BITS = 12;
    localparam int DATA_BITS  = 8;
    localparam int ID_BITS    = 6;
    localparam int NIB_BITS   = 4;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // Control byte bit positions (decoded by the controller as well)
    localparam int CB_KIND  = 7;  // 0: address byte, 1: slave command
    localparam int CB_DIR   = 6;  // address byte: 1 select, 0 reset; command: 1 read
    localparam int CB_SIZE  = 5;  // command: 1 byte pair
    localparam int CB_MULTI = 4;  // command: 1 multi-transfer

    typedef enum logic [1:0] {
        MD_CTRL = 2'd0,
        MD_RX   = 2'd1,
        MD_TX   = 2'd2
    } mode_e;
endpackage

// File: rtl/lsl_edge_sync.sv
// Brings the link clock and data line into the system clock domain and
// flags the link clock edges. Assumes each link clock phase lasts at
// least STAGES+1 system clocks, so no edge is lost.
module lsl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    input  logic bus_dat,
    output logic rise,
    output logic fall,
    output logic dat_s
);
    logic [STAGES-1:0] ck_pipe;
    logic [STAGES-1:0] dt_pipe;
    logic              ck_prev;

    // Purpose: synchroniser chains with equal delay for clock and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_pipe <= '0;
            dt_pipe <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_pipe <= {ck_pipe[STAGES-2:0], bus_clk};
            dt_pipe <= {dt_pipe[STAGES-2:0], bus_dat};
            ck_prev <= ck_pipe[STAGES-1];
        end
    end

    // Purpose: edge flags and the aligned data sample.
    always_comb begin
        rise  = ck_pipe[STAGES-1] & ~ck_prev;
        fall  = ~ck_pipe[STAGES-1] & ck_prev;
        dat_s = dt_pipe[STAGES-1];
    end
endmodule

// File: rtl/lsl_frame_eng.sv
// Frame engine: finds a start bit, counts the 12 frame bits, collects
// the header and data bits, and drives the data window when the decoder
// asks the slave to answer. Assumes the decoder replies to hdr_vld in the
// same cycle with want_talk and tx_load.
module lsl_frame_eng
    import lsl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 dat_s,
    input  logic                 want_talk,
    input  logic [DATA_BITS-1:0] tx_load,
    output logic                 hdr_vld,
    output logic                 frm_vld,
    output logic                 frm_ctl,
    output logic [DATA_BITS-1:0] frm_byte,
    output logic                 frm_talked,
    output logic                 dat_o,
    output logic                 dat_oe
);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] D_FIRST = CNT_W'(3);
    localparam logic [CNT_W-1:0] D_LAST  = CNT_W'(3 + DATA_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_AT  = CNT_W'(1);

    logic [CNT_W-1:0]     bit_cnt;
    logic                 ctl_q;
    logic [DATA_BITS-1:0] rx_sh;
    logic                 talk_q;
    logic [DATA_BITS-1:0] tx_sh;
    logic                 in_data;
    logic                 frame_end;

    // Purpose: bit-window decode shared by both processes.
    always_comb begin
        in_data   = (bit_cnt >= D_FIRST) && (bit_cnt <= D_LAST);
        frame_end = rise && (bit_cnt == LAST);
    end

    // Purpose: bit counting, header capture and data shift-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            ctl_q      <= 1'b0;
            rx_sh      <= '0;
            hdr_vld    <= 1'b0;
            frm_vld    <= 1'b0;
            frm_ctl    <= 1'b0;
            frm_byte   <= '0;
            frm_talked <= 1'b0;
        end else begin
            hdr_vld <= 1'b0;
            frm_vld <= 1'b0;
            if (rise) begin
                if (bit_cnt == '0) begin
                    if (dat_s) begin
                        bit_cnt <= CNT_W'(1);
                    end
                end else if (bit_cnt == LAST) begin
                    bit_cnt    <= '0;
                    frm_vld    <= 1'b1;
                    frm_ctl    <= ctl_q;
                    frm_byte   <= rx_sh;
                    frm_talked <= talk_q;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    if (bit_cnt == HDR_AT) begin
                        ctl_q   <= dat_s;
                        hdr_vld <= dat_s;
                    end
                    if (in_data) begin
                        rx_sh <= {dat_s, rx_sh[DATA_BITS-1:1]};
                    end
                end
            end
        end
    end

    // Purpose: load the answer byte and drive it in cycles 4 to 11.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            talk_q <= 1'b0;
            tx_sh  <= '0;
            dat_o  <= 1'b0;
            dat_oe <= 1'b0;
        end else begin
            if (hdr_vld) begin
                talk_q <= want_talk;
                tx_sh  <= tx_load;
            end else if (frame_end) begin
                talk_q <= 1'b0;
            end
            if (fall) begin
                if (bit_cnt == LAST || bit_cnt == '0) begin
                    dat_oe <= 1'b0;
                    dat_o  <= 1'b0;
                end else if (talk_q && in_data) begin
                    dat_oe <= 1'b1;
                    dat_o  <= tx_sh[0];
                    tx_sh  <= {1'b0, tx_sh[DATA_BITS-1:1]};
                end
            end
        end
    end

    // R11: the line is only driven between the turnaround bits.
    a_r11_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe |-> (bit_cnt >= D_FIRST && bit_cnt <= LAST));
    // R11: the falling edge opening cycle 12 releases the line.
    a_r11_release_last: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && bit_cnt == LAST) |=> !dat_oe);
    // R2: a header is reported only on the second bit of a frame.
    a_r2_hdr_position: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |-> (bit_cnt == CNT_W'(2)));
endmodule

// File: rtl/lsl_decoder.sv
// Transport decoder: acts on finished frames, keeps select and mode
// state, and tells the frame engine whether and what to answer.
// Assumes frm_vld and hdr_vld are one-cycle pulses from the frame engine.
module lsl_decoder
    import lsl_pkg::*;
#(
    parameter logic [ID_BITS-1:0]   SLAVE_ID  = 6'd5,
    parameter logic [DATA_BITS-1:0] INFO_BYTE = 8'h81
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_vld,
    input  logic                 frm_vld,
    input  logic                 frm_ctl,
    input  logic [DATA_BITS-1:0] frm_byte,
    input  logic                 frm_talked,
    input  logic [DATA_BITS-1:0] tx_byte,
    output logic                 want_talk,
    output logic [DATA_BITS-1:0] tx_load,
    output logic                 tx_req,
    output logic                 dat_vld,
    output logic [DATA_BITS-1:0] dat_byte,
    output logic                 cmd_vld,
    output logic [NIB_BITS-1:0]  cmd_nib,
    output logic                 loc_rst,
    output logic                 sel_o
);
    logic  sel_q;
    logic  info_q;
    logic  multi_q;
    mode_e mode_q;
    logic  id_hit;
    logic  id_zero;

    // Purpose: address match and answer selection for the frame engine.
    always_comb begin
        id_hit    = frm_byte[ID_BITS-1:0] == SLAVE_ID;
        id_zero   = frm_byte[ID_BITS-1:0] == '0;
        want_talk = sel_q && (info_q || mode_q == MD_TX);
        tx_load   = info_q ? INFO_BYTE : tx_byte;
        tx_req    = hdr_vld && sel_q && !info_q && (mode_q == MD_TX);
        sel_o     = sel_q;
    end

    // Purpose: act on each completed frame and raise the local strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            info_q   <= 1'b0;
            multi_q  <= 1'b0;
            mode_q   <= MD_CTRL;
            dat_vld  <= 1'b0;
            dat_byte <= '0;
            cmd_vld  <= 1'b0;
            cmd_nib  <= '0;
            loc_rst  <= 1'b0;
        end else begin
            dat_vld <= 1'b0;
            cmd_vld <= 1'b0;
            loc_rst <= 1'b0;
            if (frm_vld) begin
                if (!frm_ctl) begin
                    if (!frm_byte[CB_KIND]) begin
                        if (frm_byte[CB_DIR]) begin
                            sel_q   <= id_hit;
                            info_q  <= id_hit;
                            mode_q  <= MD_CTRL;
                            multi_q <= 1'b0;
                        end else if (id_hit || id_zero) begin
                            sel_q   <= 1'b0;
                            info_q  <= 1'b0;
                            mode_q  <= MD_CTRL;
                            multi_q <= 1'b0;
                            loc_rst <= 1'b1;
                        end
                    end else begin
                        info_q  <= 1'b0;
                        multi_q <= frm_byte[CB_MULTI];
                        if (sel_q && !frm_byte[CB_SIZE]) begin
                            cmd_vld <= 1'b1;
                            cmd_nib <= frm_byte[NIB_BITS-1:0];
                            mode_q  <= frm_byte[CB_DIR] ? MD_TX : MD_RX;
                        end else begin
                            mode_q <= MD_CTRL;
                        end
                    end
                end else if (frm_talked) begin
                    if (info_q) begin
                        info_q <= 1'b0;
                    end else if (!multi_q) begin
                        mode_q <= MD_CTRL;
                    end
                end else if (sel_q && mode_q == MD_RX) begin
                    dat_vld  <= 1'b1;
                    dat_byte <= frm_byte;
                    if (!multi_q) begin
                        mode_q <= MD_CTRL;
                    end
                end
            end
        end
    end

    // R3: the local reset is a single-cycle pulse.
    a_r3_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rst |=> !loc_rst);
    // R3: after a local reset the slave is deselected.
    a_r3_rst_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rst |-> !sel_q);
    // R4: a pending information answer implies selection.
    a_r4_info_selected: assert property (@(posedge clk) disable iff (!rst_n)
        info_q |-> sel_q);
    // R6: commands are accepted only while selected.
    a_r6_cmd_selected: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> sel_q);
    // R9: a single write leaves the slave in control-only mode.
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_vld && !multi_q) |-> (mode_q == MD_CTRL));
endmodule

// File: rtl/link_slave.sv
// Top of the addressed serial link slave: synchroniser, frame engine
// and transport decoder. Assumes an external pull-down on the data line
// and a link clock slow enough for the system clock to see each phase.
module link_slave
    import lsl_pkg::*;
#(
    parameter logic [ID_BITS-1:0]   SLAVE_ID    = 6'd5,
    parameter logic [DATA_BITS-1:0] INFO_BYTE   = 8'h81,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_clk,
    input  logic                 bus_dat_i,
    output logic                 bus_dat_o,
    output logic                 bus_dat_oe,
    output logic                 dat_vld,
    output logic [DATA_BITS-1:0] dat_byte,
    output logic                 cmd_vld,
    output logic [NIB_BITS-1:0]  cmd_nib,
    output logic                 tx_req,
    input  logic [DATA_BITS-1:0] tx_byte,
    output logic                 loc_rst
);
    logic                 rise;
    logic                 fall;
    logic                 dat_s;
    logic                 want_talk;
    logic [DATA_BITS-1:0] tx_load;
    logic                 hdr_vld;
    logic                 frm_vld;
    logic                 frm_ctl;
    logic [DATA_BITS-1:0] frm_byte;
    logic                 frm_talked;
    logic                 sel;

    lsl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_clk (bus_clk),
        .bus_dat (bus_dat_i),
        .rise    (rise),
        .fall    (fall),
        .dat_s   (dat_s)
    );

    lsl_frame_eng u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .dat_s      (dat_s),
        .want_talk  (want_talk),
        .tx_load    (tx_load),
        .hdr_vld    (hdr_vld),
        .frm_vld    (frm_vld),
        .frm_ctl    (frm_ctl),
        .frm_byte   (frm_byte),
        .frm_talked (frm_talked),
        .dat_o      (bus_dat_o),
        .dat_oe     (bus_dat_oe)
    );

    lsl_decoder #(.SLAVE_ID(SLAVE_ID), .INFO_BYTE(INFO_BYTE)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_vld    (hdr_vld),
        .frm_vld    (frm_vld),
        .frm_ctl    (frm_ctl),
        .frm_byte   (frm_byte),
        .frm_talked (frm_talked),
        .tx_byte    (tx_byte),
        .want_talk  (want_talk),
        .tx_load    (tx_load),
        .tx_req     (tx_req),
        .dat_vld    (dat_vld),
        .dat_byte   (dat_byte),
        .cmd_vld    (cmd_vld),
        .cmd_nib    (cmd_nib),
        .loc_rst    (loc_rst),
        .sel_o      (sel)
    );

    // R12: the data line is driven only by a selected slave.
    a_r12_drive_selected: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dat_oe |-> sel);
    // R8: a transmit request only arrives while the line is idle.
    a_r8_req_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !bus_dat_oe);
endmodule

// File: tb/sim_link_slave.sv
`timescale 1ns/1ps
// Bench: acts as the link controller, sweeps addresses and data values,
// and compares against values computed from the requirements.
module sim_link_slave;
    localparam logic [5:0] TID   = 6'd37;
    localparam logic [7:0] TINFO = 8'hC3;
    localparam int         HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic m_oe = 1'b0;
    logic m_val = 1'b0;
    logic line;
    logic s_o, s_oe;
    logic dat_vld, cmd_vld, tx_req, loc_rst;
    logic [7:0] dat_byte;
    logic [3:0] cmd_nib;
    logic [7:0] tx_byte = 8'h00;

    int n_vec = 0, n_bad = 0;
    int n_dat = 0, n_cmd = 0, n_rst = 0, n_txr = 0, n_clash = 0;
    logic [7:0] last_dat = 8'h00;
    logic [3:0] last_nib = 4'h0;
    logic [7:0] rd_byte;
    logic [11:0] oe_mask;
    bit done = 1'b0;

    assign line = m_oe ? m_val : (s_oe ? s_o : 1'b0);

    always #2.5 clk = ~clk;

    link_slave #(.SLAVE_ID(TID), .INFO_BYTE(TINFO)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_clk    (bclk),
        .bus_dat_i  (line),
        .bus_dat_o  (s_o),
        .bus_dat_oe (s_oe),
        .dat_vld    (dat_vld),
        .dat_byte   (dat_byte),
        .cmd_vld    (cmd_vld),
        .cmd_nib    (cmd_nib),
        .tx_req     (tx_req),
        .tx_byte    (tx_byte),
        .loc_rst    (loc_rst)
    );

    // Pulse monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dat_vld) begin n_dat++; last_dat = dat_byte; end
            if (cmd_vld) begin n_cmd++; last_nib = cmd_nib; end
            if (loc_rst) n_rst++;
            if (tx_req) n_txr++;
            if (m_oe && s_oe) n_clash++;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // One link bit: falling edge with master data, then rising edge sample.
    task automatic bus_bit(input logic drv, input logic val,
                           output logic smp, output logic soe);
        @(negedge clk);
        bclk = 1'b0; m_oe = drv; m_val = val;
        repeat (HALF) @(negedge clk);
        bclk = 1'b1; smp = line; soe = s_oe;
        repeat (HALF - 1) @(negedge clk);
    endtask

    // Whole frame; rd releases the line from cycle 3 on, nul releases it all.
    task automatic frame(input logic ctl, input logic [7:0] b,
                         input logic rd, input logic nul);
        logic smp, soe;
        for (int k = 0; k < 12; k++) begin
            logic drv, val;
            drv = !nul && (k < 2 || !rd);
            val = (k == 0) ? 1'b1 : (k == 1) ? ctl :
                  (k >= 3 && k <= 10) ? b[k-3] : 1'b0;
            bus_bit(drv, val, smp, soe);
            oe_mask[k] = soe;
            if (k >= 3 && k <= 10) rd_byte[k-3] = smp;
        end
        @(negedge clk);
        bclk = 1'b0; m_oe = 1'b0; m_val = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic ctrl(input logic [7:0] b); frame(1'b0, b, 1'b0, 1'b0); endtask
    task automatic wr(input logic [7:0] b);   frame(1'b1, b, 1'b0, 1'b0); endtask
    task automatic rd();                      frame(1'b1, 8'h00, 1'b1, 1'b0); endtask
    task automatic nul();                     frame(1'b0, 8'h00, 1'b0, 1'b1); endtask

    initial begin
        int d0, c0, r0, t0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 oe", s_oe, 0);
        chk("R1 strobes", {dat_vld, cmd_vld, tx_req, loc_rst}, 0);

        // R2: null frames and an unselected read do nothing
        d0 = n_dat; c0 = n_cmd; t0 = n_txr;
        nul(); nul();
        chk("R2 null frames quiet", (n_dat - d0) + (n_cmd - c0) + (n_txr - t0), 0);
        rd();
        chk("R12 unselected read", rd_byte, 0);
        chk("R12 unselected mask", oe_mask, 0);

        // R4 R5: select sweep over every address
        for (int id = 0; id < 64; id++) begin
            r0 = n_rst;
            ctrl(8'h40 | 8'(id));
            rd();
            chk("R4 select answer", rd_byte, (id == int'(TID)) ? int'(TINFO) : 0);
            chk("R11 answer window", oe_mask, (id == int'(TID)) ? 12'h7F8 : 12'h000);
            chk("R5 no reset on select", n_rst - r0, 0);
        end

        // R3: reset sweep, each after selecting this slave
        for (int k = 0; k < 64; k++) begin
            bit hit;
            hit = (k == 0) || (k == int'(TID));
            ctrl(8'h40 | 8'(TID));
            r0 = n_rst;
            ctrl(8'(k));
            chk("R3 reset pulse", n_rst - r0, hit ? 1 : 0);
            rd();
            chk("R3 state after reset", rd_byte, hit ? 0 : int'(TINFO));
        end

        // R6 R7 R9 R2: multi write over every byte value, nulls between
        ctrl(8'h40 | 8'(TID)); rd();
        c0 = n_cmd;
        ctrl(8'h90 | 8'h5);
        chk("R6 cmd strobe", n_cmd - c0, 1);
        chk("R6 cmd nibble", last_nib, 5);
        for (int v = 0; v < 256; v++) begin
            d0 = n_dat;
            wr(8'(v));
            chk("R7 write byte", last_dat, v);
            chk("R9 multi write count", n_dat - d0, 1);
            if ((v % 16) == 15) nul();
        end

        // R10 R9: replace with single write
        c0 = n_cmd; d0 = n_dat;
        ctrl(8'h80 | 8'h9);
        chk("R10 new command", last_nib, 9);
        wr(8'h3C);
        wr(8'h77);
        chk("R9 single write count", n_dat - d0, 1);
        chk("R9 single write byte", last_dat, 8'h3C);

        // R8 R9: multi read stream
        ctrl(8'hD0 | 8'h3);
        for (int i = 0; i < 64; i++) begin
            tx_byte = 8'((i * 37 + 11) % 256);
            t0 = n_txr;
            rd();
            chk("R8 read byte", rd_byte, int'(tx_byte));
            chk("R8 one request", n_txr - t0, 1);
            chk("R11 read window", oe_mask, 12'h7F8);
        end

        // R9 R10: single read then control-only
        ctrl(8'hC0 | 8'h6);
        tx_byte = 8'h96;
        rd();
        chk("R9 single read", rd_byte, 8'h96);
        t0 = n_txr; d0 = n_dat;
        rd();
        chk("R9 read after single", rd_byte, 0);
        chk("R9 no request after single", n_txr - t0, 0);
        wr(8'h11);
        chk("R9 control only ignores data", n_dat - d0, 0);

        // R13: byte-pair size command
        c0 = n_cmd; d0 = n_dat; t0 = n_txr;
        ctrl(8'hE0);
        wr(8'h22);
        rd();
        chk("R13 no strobe", n_cmd - c0, 0);
        chk("R13 no data", n_dat - d0, 0);
        chk("R13 no drive", oe_mask, 0);

        // R5 R12 R6: deselect, then commands and data ignored
        ctrl(8'h40);
        c0 = n_cmd; d0 = n_dat;
        ctrl(8'h81);
        wr(8'h44);
        rd();
        chk("R6 unselected cmd", n_cmd - c0, 0);
        chk("R12 unselected data", n_dat - d0, 0);
        chk("R12 unselected drive", oe_mask, 0);
        chk("R12 no contention", n_clash, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule